// File: doc/BRIEF.md
# Shift-Register Clock Divider Pair

This block holds the two programmable dividers that set a synthesizer's reference and feedback ratios. Neither divider uses a binary counter and a compare. Each one counts with a linear feedback shift register. When the register reaches its all-ones terminal state, it reloads a value that software has written, and it toggles its divided output. The divisor N is set by the reload value: software loads the state that lies N-1 shift steps ahead of the terminal state.

The reference divider is 6 bits wide and covers divisors 1 to 64. The feedback divider is 8 bits wide and covers divisors 2 to 160. Each divider has its own reload write port, its own enable, a toggling divided output and a one-cycle terminal pulse.

A newly written reload value is held in a staging register. It is applied only at the next terminal event, so the interval already running always completes at full length.

Top module: `pll_lfsr_divider_pair`

## Requirements
- R1: The reference register shifts left by one each enabled cycle. Its new bit 0 is the XNOR of bits 5 and 4, and the all-zero state steps to the all-ones terminal state. All-ones is never kept across an enabled cycle unless the staged value is itself all-ones, so the counter cannot lock up there.
- R2: The feedback register shifts left by one each enabled cycle. Its new bit 0 is the XNOR of bits 7, 3, 2 and 1, and the all-zero state steps to the all-ones terminal state.
- R3: Reference reload values give terminal pulses exactly N enabled cycles apart: 0x3F gives 1, 0x00 gives 2, 0x20 gives 3, 0x10 gives 4 and 0x01 gives 64.
- R4: Feedback reload values give terminal pulses exactly N enabled cycles apart: 0x00 gives 2, 0x80 gives 3, 0xC0 gives 4 and 0x69 gives 160.
- R5: A divided output inverts at each terminal event and at no other time.
- R6: A terminal output is high for exactly the one cycle after an enabled clock edge at which its register held the terminal state.
- R7: A reload write goes into the staging register only. The interval that is running is not shortened. A write made on the same edge as a terminal event takes effect at the terminal event after that one.
- R8: While its enable is low, a divider holds its register and its divided output, and its terminal output stays low. Counting resumes where it stopped.
- R9: An active-low asynchronous reset sets each register to the terminal state, sets each staged value to all-ones (divisor 1) and drives every output low. The first enabled edge after reset is therefore a terminal event.
- R10: The two dividers are independent. Writes to one, or its enable, do not change the other's period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_en_i | input | 1 | Reference divider count enable |
| ref_wr_i | input | 1 | Reference reload write strobe |
| ref_val_i | input | 6 | Reference reload value |
| ref_clk_o | output | 1 | Reference divided output |
| ref_term_o | output | 1 | Reference terminal pulse |
| fb_en_i | input | 1 | Feedback divider count enable |
| fb_wr_i | input | 1 | Feedback reload write strobe |
| fb_val_i | input | 8 | Feedback reload value |
| fb_clk_o | output | 1 | Feedback divided output |
| fb_term_o | output | 1 | Feedback terminal pulse |

## Verification
The assertions assume that reset is asserted from time zero and that the enables and write strobes are synchronous to clk_i. They make no assumption about which reload values are legal, since every register state lies on the sequence. The stimulus drives all inputs on the falling edge. Random divisors are drawn only from each divider's supported range, and the bench converts each divisor to a reload value by walking the feedback rule forward from 0x01. This keeps every reload inside the documented ratio range, while the directed cases add the range ends, mid-interval writes, writes on a terminal edge, enable gaps and reset while the outputs are high.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;
  localparam int unsigned REF_W = 6;
  localparam int unsigned FB_W  = 8;
  localparam logic [REF_W-1:0] REF_TAPS = 6'h30;
  localparam logic [FB_W-1:0]  FB_TAPS  = 8'h8E;

  // XNOR feedback over the selected tap bits
  function automatic logic fb_xnor(input logic [31:0] state, input logic [31:0] taps);
    return ~(^(state & taps));
  endfunction
endpackage

// File: rtl/lfsr_next.sv
module lfsr_next #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] TERM = '1,
  parameter logic [W-1:0] PRE_TERM = '0
) (
  input  logic [W-1:0] state_i,
  output logic [W-1:0] next_o
);
  import lfsr_div_pkg::*;

  logic fb;
  assign fb = fb_xnor(32'(state_i), 32'(TAPS));

  always_comb begin
    if (state_i == PRE_TERM) next_o = TERM;
    else                     next_o = {state_i[W-2:0], fb};
  end
endmodule

// File: rtl/div_reload_reg.sv
module div_reload_reg #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] staged_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   staged_o <= RST_VAL;
    else if (wr_i) staged_o <= val_i;
  end

  // R7
  stage_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> staged_o == $past(val_i));
  // R7
  stage_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(staged_o));
endmodule

// File: rtl/lfsr_divider.sv
module lfsr_divider #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] TERM = '1,
  parameter logic [W-1:0] PRE_TERM = '0,
  parameter logic [W-1:0] RST_RELOAD = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         wr_i,
  input  logic [W-1:0] val_i,
  output logic         clk_o,
  output logic         term_o
);
  logic [W-1:0] lfsr_q, lfsr_nxt, staged;
  logic         at_term, clk_q, term_q;

  assign at_term = (lfsr_q == TERM);

  lfsr_next #(.W(W), .TAPS(TAPS), .TERM(TERM), .PRE_TERM(PRE_TERM)) i_next (
    .state_i (lfsr_q),
    .next_o  (lfsr_nxt)
  );

  div_reload_reg #(.W(W), .RST_VAL(RST_RELOAD)) i_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .val_i    (val_i),
    .staged_o (staged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= TERM;
      clk_q  <= 1'b0;
      term_q <= 1'b0;
    end else begin
      term_q <= en_i && at_term;
      if (en_i) begin
        lfsr_q <= at_term ? staged : lfsr_nxt;
        if (at_term) clk_q <= ~clk_q;
      end
    end
  end

  assign clk_o  = clk_q;
  assign term_o = term_q;

  // R1
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lfsr_q == TERM) |=> lfsr_q == $past(staged));
  // R1
  no_stick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lfsr_q == TERM && staged != TERM) |=> lfsr_q != TERM);
  // R5
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o == (clk_o != $past(clk_o)));
  // R6
  term_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> ($past(en_i) && $past(lfsr_q) == TERM));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> ($stable(lfsr_q) && $stable(clk_o) && !term_o));
endmodule

// File: rtl/pll_lfsr_divider_pair.sv
module pll_lfsr_divider_pair
  import lfsr_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_en_i,
  input  logic             ref_wr_i,
  input  logic [REF_W-1:0] ref_val_i,
  output logic             ref_clk_o,
  output logic             ref_term_o,
  input  logic             fb_en_i,
  input  logic             fb_wr_i,
  input  logic [FB_W-1:0]  fb_val_i,
  output logic             fb_clk_o,
  output logic             fb_term_o
);
  lfsr_divider #(
    .W(REF_W), .TAPS(REF_TAPS), .TERM('1), .PRE_TERM('0), .RST_RELOAD('1)
  ) i_ref_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ref_en_i),
    .wr_i   (ref_wr_i),
    .val_i  (ref_val_i),
    .clk_o  (ref_clk_o),
    .term_o (ref_term_o)
  );

  lfsr_divider #(
    .W(FB_W), .TAPS(FB_TAPS), .TERM('1), .PRE_TERM('0), .RST_RELOAD('1)
  ) i_fb_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (fb_en_i),
    .wr_i   (fb_wr_i),
    .val_i  (fb_val_i),
    .clk_o  (fb_clk_o),
    .term_o (fb_term_o)
  );
endmodule

// File: tb/test_pll_lfsr_divider_pair.sv
module test_pll_lfsr_divider_pair;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 600;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_en_i = 1'b0, ref_wr_i = 1'b0, fb_en_i = 1'b0, fb_wr_i = 1'b0;
  logic [5:0] ref_val_i = '0;
  logic [7:0] fb_val_i = '0;
  logic ref_clk_o, ref_term_o, fb_clk_o, fb_term_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [5:0] seq6 [64];
  logic [7:0] seq8 [256];

  pll_lfsr_divider_pair i_pll_lfsr_divider_pair (
    .clk_i, .rst_ni,
    .ref_en_i, .ref_wr_i, .ref_val_i, .ref_clk_o, .ref_term_o,
    .fb_en_i, .fb_wr_i, .fb_val_i, .fb_clk_o, .fb_term_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // feedback rules from R1 and R2
  function automatic logic [5:0] nxt6(input logic [5:0] s);
    return (s == 6'h00) ? 6'h3F : {s[4:0], ~(s[5] ^ s[4])};
  endfunction
  function automatic logic [7:0] nxt8(input logic [7:0] s);
    return (s == 8'h00) ? 8'hFF : {s[6:0], ~(s[7] ^ s[3] ^ s[2] ^ s[1])};
  endfunction

  function automatic logic t_of(input bit fb);
    return fb ? fb_term_o : ref_term_o;
  endfunction
  function automatic logic c_of(input bit fb);
    return fb ? fb_clk_o : ref_clk_o;
  endfunction

  task automatic wait_term(input bit fb, input string req, output int cnt);
    logic prev;
    prev = c_of(fb);
    cnt = 0;
    do begin
      @(negedge clk_i);
      cnt++;
      if (t_of(fb)) chk(c_of(fb) != prev, "R5 toggle at terminal", c_of(fb), !prev);
      else if (c_of(fb) != prev) chk(0, "R5 toggle without terminal", c_of(fb), prev);
    end while (!t_of(fb) && cnt < LIMIT);
    if (!t_of(fb)) chk(0, {req, " terminal timeout"}, cnt, -1);
  endtask

  task automatic write(input bit fb, input logic [7:0] v);
    @(negedge clk_i);
    if (fb) begin fb_wr_i = 1'b1; fb_val_i = v; end
    else begin ref_wr_i = 1'b1; ref_val_i = v[5:0]; end
    @(negedge clk_i);
    ref_wr_i = 1'b0;
    fb_wr_i = 1'b0;
  endtask

  task automatic measure(input bit fb, input logic [7:0] v, input int n, input string req);
    int c;
    write(fb, v);
    wait_term(fb, req, c);
    wait_term(fb, req, c);
    wait_term(fb, req, c);
    chk(c == n, req, c, n);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before all requirements were checked");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c, n;
    void'($urandom(32'd4242));
    seq6[0] = 6'h01;
    for (int i = 1; i < 64; i++) seq6[i] = nxt6(seq6[i-1]);
    seq8[0] = 8'h01;
    for (int i = 1; i < 256; i++) seq8[i] = nxt8(seq8[i-1]);

    // R9 reset state
    #(CLK_PERIOD * 3);
    chk(ref_clk_o == 0, "R9 ref_clk reset", ref_clk_o, 0);
    chk(ref_term_o == 0, "R9 ref_term reset", ref_term_o, 0);
    chk(fb_clk_o == 0, "R9 fb_clk reset", fb_clk_o, 0);
    chk(fb_term_o == 0, "R9 fb_term reset", fb_term_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R8 disabled after reset: nothing moves
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk(!ref_term_o && !ref_clk_o && !fb_term_o && !fb_clk_o, "R8 idle while disabled",
          {ref_term_o, ref_clk_o, fb_term_o, fb_clk_o}, 0);
    end
    // R9 first enabled edge is terminal, staged divisor 1
    ref_en_i = 1'b1;
    wait_term(0, "R9", c);
    chk(c == 1, "R9 ref first terminal", c, 1);
    wait_term(0, "R9", c);
    chk(c == 1, "R9 ref reset divisor", c, 1);
    fb_en_i = 1'b1;
    wait_term(1, "R9", c);
    chk(c == 1, "R9 fb first terminal", c, 1);
    wait_term(1, "R9", c);
    chk(c == 1, "R9 fb reset divisor", c, 1);

    // R3 stated reference values
    measure(0, 8'h3F, 1, "R3 ref 0x3F");
    measure(0, 8'h00, 2, "R3 ref 0x00");
    measure(0, 8'h20, 3, "R3 ref 0x20");
    measure(0, 8'h10, 4, "R3 ref 0x10");
    measure(0, 8'h01, 64, "R3 ref 0x01");
    // R4 stated feedback values
    measure(1, 8'h00, 2, "R4 fb 0x00");
    measure(1, 8'h80, 3, "R4 fb 0x80");
    measure(1, 8'hC0, 4, "R4 fb 0xC0");
    measure(1, 8'h69, 160, "R4 fb 0x69");

    // R7 mid-interval write does not cut the running 160 interval
    wait_term(1, "R7", c);
    write(1, seq8[256-5]);
    wait_term(1, "R7", c);
    chk(c == 158, "R7 running interval kept", c, 158);
    wait_term(1, "R7", c);
    chk(c == 5, "R7 new divisor applied", c, 5);

    // R7 write on a terminal edge: ref divisor 2, write divisor 3
    measure(0, 8'h00, 2, "R3 ref 0x00 again");
    write(0, 8'h20);
    wait_term(0, "R7", c);
    chk(c == 2, "R7 terminal-edge write deferred", c, 2);
    wait_term(0, "R7", c);
    chk(c == 3, "R7 deferred divisor applied", c, 3);

    // R8 enable gap of 7 cycles
    wait_term(0, "R8", c);
    ref_en_i = 1'b0;
    begin
      logic held;
      held = ref_clk_o;
      for (int i = 0; i < 7; i++) begin
        @(negedge clk_i);
        chk(!ref_term_o && ref_clk_o == held, "R8 frozen", {ref_term_o, ref_clk_o}, {1'b0, held});
      end
    end
    ref_en_i = 1'b1;
    wait_term(0, "R8", c);
    chk(c == 3, "R8 count resumes", c, 3);

    // R1 / R2 random divisors from the feedback rule
    for (int i = 0; i < 8; i++) begin
      n = 1 + int'($urandom_range(63));
      measure(0, {2'b00, seq6[64-n]}, n, "R1 ref random");
    end
    measure(0, 8'h10, 4, "R3 ref 0x10 for R10");
    for (int i = 0; i < 6; i++) begin
      n = 2 + int'($urandom_range(158));
      measure(1, seq8[256-n], n, "R2 fb random");
    end
    // R10 ref unaffected by fb activity
    wait_term(0, "R10", c);
    wait_term(0, "R10", c);
    chk(c == 4, "R10 ref period kept", c, 4);

    // R9 asynchronous reset while outputs high
    while (!(ref_clk_o && fb_clk_o)) begin
      @(negedge clk_i);
      if (!ref_clk_o) begin ref_en_i = 1'b1; end
    end
    rst_ni = 1'b0;
    #1;
    chk(ref_clk_o == 0 && fb_clk_o == 0, "R9 async reset clears outputs",
        {ref_clk_o, fb_clk_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule